// File: doc/BRIEF.md
# Bus Bandwidth Exerciser Engine

This block generates synthetic traffic on a generic burst-master bus so that a host bridge and the memory behind it can be benchmarked. It contains two traffic sources, a read channel and a write channel. Each has its own base address, burst length and burst count, and each can run forever in loop mode. When both channels have work, an arbiter interleaves their bursts, so read and write traffic run concurrently. Write beats carry an address-derived incrementing pattern. Read beats are compared against the same pattern, and every beat that differs is counted.

Software programs the block and then watches it by polling a small word-addressed register file, since the block raises no interrupt. Each channel has a counter of completed bursts, and a cycle counter runs whenever any channel is busy. Software divides the transferred bytes by the elapsed cycles to get bandwidth. The block issues one burst at a time. A burst is a command handshake followed by the given number of data beats.

Top module: `bwx_engine`

## Requirements
- R1: After synchronous active-low reset, every register reads zero and no command, write beat or burst is in progress.
- R2: Register word 1 (read base), 2 (read burst count), 3 (read length), 4 (write base), 5 (write burst count), 6 (write length) and 7 (region size in bytes) read back what was last written. The length registers keep only their low LEN_W bits.
- R3: Control word 0 has bit0 = read enable, bit1 = write enable, bit2 = read loop and bit3 = write loop. With an enable set and loop clear, a channel issues exactly its programmed number of bursts and then stops. A count of zero issues none. Word 9 (read done) and word 10 (write done) hold the completed-burst counts.
- R4: With loop set, a channel keeps issuing bursts past its count until its enable is cleared. The burst in flight then completes, and no new burst starts.
- R5: Only one burst is in flight at a time. When both channels are pending, bursts alternate between them, with read first after reset.
- R6: bus_cmd_valid, once raised, stays high with address, direction and beat count unchanged until bus_cmd_ready accepts it.
- R7: Each burst of a channel starts at base + offset. The offset begins at zero and advances by beats x DATA_W/8 bytes after each burst. It returns to zero when the advanced value is greater than or equal to the region size.
- R8: Each write beat at byte address A carries A + 4j in 32-bit lane j (bits 32j+31:32j). The beat is held until bus_wready.
- R9: Word 12 counts read beats whose data differ from the R8 pattern for their address.
- R10: Word 11 increases by one on every cycle in which a channel is pending or owns the burst in flight. It holds while both are idle. Word 8 shows bit0 = read busy and bit1 = write busy.
- R11: Writing control word 0 with bit4 set clears the done, cycle and mismatch counters and both channel offsets.
- R12: A programmed length of zero issues one-beat bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| bus_cmd_valid | output | 1 | Burst command valid |
| bus_cmd_ready | input | 1 | Burst command accepted |
| bus_cmd_write | output | 1 | 1 = write burst, 0 = read burst |
| bus_cmd_addr | output | 32 | Burst start byte address |
| bus_cmd_beats | output | LEN_W | Beats in the burst |
| bus_wvalid | output | 1 | Write beat valid |
| bus_wready | input | 1 | Write beat accepted |
| bus_wdata | output | DATA_W | Write beat data |
| bus_rvalid | input | 1 | Read beat valid |
| bus_rdata | input | DATA_W | Read beat data |

## Verification
The bench runs single-channel read runs, single-channel write runs and mixed runs. These use lengths that make the offset wrap, never wrap, or always return to the base (region zero), which separates a wrong step or wrap comparison from a wrong base. One read run returns corrupted data, so a checker that never counts can be told apart from one that always counts. A run with zero counts separates "pending" from "enabled". A long run with both channels in loop mode exposes any break in alternation or a burst that starts after the enable is dropped. A zero length tests the one-beat substitute. The bus model stalls the command, write and read paths pseudo-randomly, so hold and stability faults show up as wrong addresses or data.

// File: rtl/bwx_pkg.sv
// Shared register indices and channel configuration type for the exerciser.
package bwx_pkg;
    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] RA_CTRL     = 4'd0;
    localparam logic [REG_AW-1:0] RA_RD_BASE  = 4'd1;
    localparam logic [REG_AW-1:0] RA_RD_CNT   = 4'd2;
    localparam logic [REG_AW-1:0] RA_RD_LEN   = 4'd3;
    localparam logic [REG_AW-1:0] RA_WR_BASE  = 4'd4;
    localparam logic [REG_AW-1:0] RA_WR_CNT   = 4'd5;
    localparam logic [REG_AW-1:0] RA_WR_LEN   = 4'd6;
    localparam logic [REG_AW-1:0] RA_REGION   = 4'd7;
    localparam logic [REG_AW-1:0] RA_STATUS   = 4'd8;
    localparam logic [REG_AW-1:0] RA_RD_DONE  = 4'd9;
    localparam logic [REG_AW-1:0] RA_WR_DONE  = 4'd10;
    localparam logic [REG_AW-1:0] RA_CYCLES   = 4'd11;
    localparam logic [REG_AW-1:0] RA_MISMATCH = 4'd12;

    // Control word bit positions
    localparam int CB_RD_EN   = 0;
    localparam int CB_WR_EN   = 1;
    localparam int CB_RD_LOOP = 2;
    localparam int CB_WR_LOOP = 3;
    localparam int CB_CLEAR   = 4;

    typedef struct packed {
        logic        en;
        logic        loop;
        logic [31:0] base;
        logic [31:0] count;
    } chan_cfg_t;
endpackage

// File: rtl/bwx_regs.sv
// Register file: holds the channel configuration and the region size, and
// decodes the clear strobe. It also multiplexes status and counters for
// polling reads.
// Assumes single-cycle writes and a combinational read on reg_addr.
module bwx_regs
    import bwx_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output chan_cfg_t         cfg_rd,
    output chan_cfg_t         cfg_wr,
    output logic [LEN_W-1:0]  len_rd,
    output logic [LEN_W-1:0]  len_wr,
    output logic [31:0]       region,
    output logic              clr,
    input  logic [1:0]        busy,
    input  logic [31:0]       rd_done,
    input  logic [31:0]       wr_done,
    input  logic [31:0]       cycles,
    input  logic [31:0]       mismatch
);
    localparam int PAD_W = 32 - LEN_W;

    // Clear strobe: a control write with the clear bit set
    assign clr = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[CB_CLEAR];

    // Configuration storage, updated by register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rd <= '0;
            cfg_wr <= '0;
            len_rd <= '0;
            len_wr <= '0;
            region <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_CTRL: begin
                    cfg_rd.en   <= reg_wdata[CB_RD_EN];
                    cfg_wr.en   <= reg_wdata[CB_WR_EN];
                    cfg_rd.loop <= reg_wdata[CB_RD_LOOP];
                    cfg_wr.loop <= reg_wdata[CB_WR_LOOP];
                end
                RA_RD_BASE: cfg_rd.base  <= reg_wdata;
                RA_RD_CNT:  cfg_rd.count <= reg_wdata;
                RA_RD_LEN:  len_rd       <= reg_wdata[LEN_W-1:0];
                RA_WR_BASE: cfg_wr.base  <= reg_wdata;
                RA_WR_CNT:  cfg_wr.count <= reg_wdata;
                RA_WR_LEN:  len_wr       <= reg_wdata[LEN_W-1:0];
                RA_REGION:  region       <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Read multiplexer for polling
    always_comb begin
        case (reg_addr)
            RA_CTRL:     reg_rdata = {28'd0, cfg_wr.loop, cfg_rd.loop, cfg_wr.en, cfg_rd.en};
            RA_RD_BASE:  reg_rdata = cfg_rd.base;
            RA_RD_CNT:   reg_rdata = cfg_rd.count;
            RA_RD_LEN:   reg_rdata = {{PAD_W{1'b0}}, len_rd};
            RA_WR_BASE:  reg_rdata = cfg_wr.base;
            RA_WR_CNT:   reg_rdata = cfg_wr.count;
            RA_WR_LEN:   reg_rdata = {{PAD_W{1'b0}}, len_wr};
            RA_REGION:   reg_rdata = region;
            RA_STATUS:   reg_rdata = {30'd0, busy};
            RA_RD_DONE:  reg_rdata = rd_done;
            RA_WR_DONE:  reg_rdata = wr_done;
            RA_CYCLES:   reg_rdata = cycles;
            RA_MISMATCH: reg_rdata = mismatch;
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bwx_chan.sv
// Channel sequencer: decides whether the channel has another burst to issue
// and computes that burst's start address inside the wrapping region. It also
// counts completed bursts.
// Assumes burst_done pulses for one cycle at the last beat of its own burst.
module bwx_chan
    import bwx_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int BYTES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  chan_cfg_t        cfg,
    input  logic [LEN_W-1:0] len,
    input  logic [31:0]      region,
    input  logic             burst_done,
    output logic             pending,
    output logic [31:0]      burst_addr,
    output logic [LEN_W-1:0] beats,
    output logic [31:0]      done_cnt
);
    logic [31:0] offset;
    logic [31:0] step;
    logic [31:0] next_off;

    assign beats      = (len == '0) ? LEN_W'(1) : len;
    assign step       = 32'(beats) * 32'(BYTES);
    assign next_off   = offset + step;
    assign pending    = cfg.en && (cfg.loop || (done_cnt < cfg.count));
    assign burst_addr = cfg.base + offset;

    // Offset advance with region wrap, and completed-burst count
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            offset   <= '0;
            done_cnt <= '0;
        end else if (burst_done) begin
            offset   <= (next_off >= region) ? 32'd0 : next_off;
            done_cnt <= done_cnt + 32'd1;
        end
    end
endmodule

// File: rtl/bwx_arb.sv
// Two-way round-robin arbiter: a lone requester wins; when both request, the
// one that did not win last time is granted. Index 0 wins first after reset.
// Assumes take is raised only in a cycle where the grant is consumed.
module bwx_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic       take,
    output logic [1:0] gnt
);
    logic last;

    // Grant selection
    always_comb begin
        if (req == 2'b11) gnt = last ? 2'b01 : 2'b10;
        else              gnt = req;
    end

    // Remember the most recent winner
    always_ff @(posedge clk) begin
        if (!rst_n)    last <= 1'b1;
        else if (take) last <= gnt[1];
    end
endmodule

// File: rtl/bwx_engine.sv
// Bus bandwidth exerciser top: arbitrates the read and write sequencers onto
// one burst master and generates the address pattern for write beats. It
// checks read beats against that pattern and counts busy cycles.
// Assumes DATA_W is 32 or 64 and one burst is outstanding at a time.
module bwx_engine
    import bwx_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              bus_cmd_valid,
    input  logic              bus_cmd_ready,
    output logic              bus_cmd_write,
    output logic [31:0]       bus_cmd_addr,
    output logic [LEN_W-1:0]  bus_cmd_beats,
    output logic              bus_wvalid,
    input  logic              bus_wready,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rvalid,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int BYTES = DATA_W / 8;
    localparam int LANES = DATA_W / 32;

    typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_DATA} st_e;

    chan_cfg_t         cfg_rd, cfg_wr;
    chan_cfg_t         ch_cfg   [2];
    logic [LEN_W-1:0]  len_rd, len_wr;
    logic [LEN_W-1:0]  ch_len   [2];
    logic [31:0]       ch_addr  [2];
    logic [LEN_W-1:0]  ch_beats [2];
    logic [31:0]       ch_done  [2];
    logic [1:0]        pend, gnt, done_pulse, busy;
    logic [31:0]       region, cyc_cnt, mism_cnt;
    logic              clr;

    st_e               state;
    logic              sel_wr;
    logic [31:0]       beat_addr;
    logic [LEN_W-1:0]  left;
    logic [DATA_W-1:0] pattern;
    logic              take, beat, last_beat;

    assign ch_cfg[0] = cfg_rd;
    assign ch_cfg[1] = cfg_wr;
    assign ch_len[0] = len_rd;
    assign ch_len[1] = len_wr;

    bwx_regs #(.LEN_W(LEN_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .len_rd(len_rd), .len_wr(len_wr),
        .region(region), .clr(clr), .busy(busy),
        .rd_done(ch_done[0]), .wr_done(ch_done[1]),
        .cycles(cyc_cnt), .mismatch(mism_cnt)
    );

    // Channel 0 is the read sequencer, channel 1 the write sequencer
    for (genvar c = 0; c < 2; c++) begin : g_chan
        bwx_chan #(.LEN_W(LEN_W), .BYTES(BYTES)) i_chan (
            .clk(clk), .rst_n(rst_n), .clr(clr), .cfg(ch_cfg[c]),
            .len(ch_len[c]), .region(region), .burst_done(done_pulse[c]),
            .pending(pend[c]), .burst_addr(ch_addr[c]),
            .beats(ch_beats[c]), .done_cnt(ch_done[c])
        );
    end

    bwx_arb i_arb (
        .clk(clk), .rst_n(rst_n), .req(pend), .take(take), .gnt(gnt)
    );

    // Address-derived pattern: lane j holds beat address + 4j
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign pattern[32*j +: 32] = beat_addr + 32'(4 * j);
    end

    assign take       = (state == ST_IDLE) && (gnt != 2'b00);
    assign beat       = (state == ST_DATA) && (sel_wr ? bus_wready : bus_rvalid);
    assign last_beat  = beat && (left == LEN_W'(1));
    assign done_pulse = {last_beat && sel_wr, last_beat && !sel_wr};
    assign busy       = {pend[1] || ((state != ST_IDLE) && sel_wr),
                         pend[0] || ((state != ST_IDLE) && !sel_wr)};

    assign bus_cmd_valid = (state == ST_CMD);
    assign bus_cmd_write = sel_wr;
    assign bus_wvalid    = (state == ST_DATA) && sel_wr;
    assign bus_wdata     = pattern;

    // Burst sequencing: pick a channel, offer the command, move the beats
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            sel_wr        <= 1'b0;
            bus_cmd_addr  <= '0;
            bus_cmd_beats <= '0;
            beat_addr     <= '0;
            left          <= '0;
        end else begin
            case (state)
                ST_IDLE: if (take) begin
                    sel_wr        <= gnt[1];
                    bus_cmd_addr  <= gnt[1] ? ch_addr[1] : ch_addr[0];
                    bus_cmd_beats <= gnt[1] ? ch_beats[1] : ch_beats[0];
                    state         <= ST_CMD;
                end
                ST_CMD: if (bus_cmd_ready) begin
                    beat_addr <= bus_cmd_addr;
                    left      <= bus_cmd_beats;
                    state     <= ST_DATA;
                end
                ST_DATA: if (beat) begin
                    beat_addr <= beat_addr + 32'(BYTES);
                    left      <= left - LEN_W'(1);
                    if (left == LEN_W'(1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Read data check against the expected pattern
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                                  mism_cnt <= '0;
        else if (beat && !sel_wr && (bus_rdata != pattern)) mism_cnt <= mism_cnt + 32'd1;
    end

    // Elapsed-cycle counter, running while any channel is busy
    always_ff @(posedge clk) begin
        if (!rst_n || clr)    cyc_cnt <= '0;
        else if (busy != '0) cyc_cnt <= cyc_cnt + 32'd1;
    end
endmodule

// File: rtl/bwx_engine_chk.sv
// Protocol and counter checks for the exerciser, bound to the top module.
module bwx_engine_chk #(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_write,
    input logic [31:0]       cmd_addr,
    input logic [LEN_W-1:0]  cmd_beats,
    input logic              wvalid,
    input logic              wready,
    input logic [DATA_W-1:0] wdata,
    input logic [1:0]        busy,
    input logic [31:0]       cycles,
    input logic              clr
);
    // R6: command held stable until accepted
    a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)
                                       && $stable(cmd_write) && $stable(cmd_beats)));

    // R8: write beat held until accepted
    a_r8_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && !wready) |=> (wvalid && $stable(wdata)));

    // R5: command phase and write data phase never overlap
    a_r5_one_burst: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !wvalid);

    // R12: a command never carries zero beats
    a_r12_beats_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_beats != '0));

    // R10: cycle counter holds while idle
    a_r10_cycles_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy == 2'b00) && !clr) |=> $stable(cycles));

    // R10: cycle counter steps by one while busy
    a_r10_cycles_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy != 2'b00) && !clr) |=> (cycles == $past(cycles) + 32'd1));
endmodule

bind bwx_engine bwx_engine_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(bus_cmd_valid), .cmd_ready(bus_cmd_ready),
    .cmd_write(bus_cmd_write), .cmd_addr(bus_cmd_addr), .cmd_beats(bus_cmd_beats),
    .wvalid(bus_wvalid), .wready(bus_wready), .wdata(bus_wdata),
    .busy(busy), .cycles(cyc_cnt), .clr(clr)
);

// File: tb/test_bwx_engine.sv
`timescale 1ns/1ps
module test_bwx_engine;
    localparam int DW = 64;
    localparam int LW = 8;
    localparam int B  = DW / 8;

    typedef struct packed {
        logic       rd;
        logic       wr;
        logic [7:0] rcnt;
        logic [7:0] wcnt;
        logic [7:0] len;
        logic [15:0] region;
        logic       inj;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'd3, 8'd0, 8'd4, 16'h0100, 1'b0},  // read only
        '{1'b0, 1'b1, 8'd0, 8'd5, 8'd2, 16'h0040, 1'b0},  // write only, wraps
        '{1'b1, 1'b1, 8'd4, 8'd2, 8'd8, 16'h1000, 1'b0},  // mixed
        '{1'b1, 1'b0, 8'd2, 8'd0, 8'd3, 16'h0000, 1'b1},  // corrupted reads, region 0
        '{1'b0, 1'b1, 8'd0, 8'd4, 8'd0, 16'h0020, 1'b0},  // zero length
        '{1'b1, 1'b1, 8'd0, 8'd0, 8'd4, 16'h0100, 1'b0}   // zero counts
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          bus_cmd_valid, bus_cmd_write, bus_wvalid;
    logic          bus_cmd_ready = 1'b0;
    logic [31:0]   bus_cmd_addr;
    logic [LW-1:0] bus_cmd_beats;
    logic          bus_wready = 1'b0;
    logic [DW-1:0] bus_wdata;
    logic          bus_rvalid = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;

    // Bus model state and reference offsets
    logic [7:0]  lfsr = 8'h5a;
    int          rd_left = 0, rd_next = 0;
    logic [31:0] rd_a = '0, rd_next_a = '0, wr_a = '0;
    logic        inj = 1'b0;
    logic [31:0] m_rbase = '0, m_wbase = '0, m_roff = '0, m_woff = '0, m_region = '0;
    int          m_rlen = 1, m_wlen = 1;
    logic        expect_alt = 1'b0, have_last = 1'b0, last_w = 1'b0;

    bwx_engine #(.DATA_W(DW), .LEN_W(LW)) i_bwx_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_cmd_valid(bus_cmd_valid), .bus_cmd_ready(bus_cmd_ready),
        .bus_cmd_write(bus_cmd_write), .bus_cmd_addr(bus_cmd_addr),
        .bus_cmd_beats(bus_cmd_beats), .bus_wvalid(bus_wvalid),
        .bus_wready(bus_wready), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
    );

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] pat(input logic [31:0] a);
        logic [DW-1:0] r;
        for (int j = 0; j < DW / 32; j++) r[32*j +: 32] = a + 32'(4 * j);
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_w(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_r(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_all();
        reg_w(4'd0, 32'h10);
        m_roff = '0;
        m_woff = '0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 20000; k++) begin
            reg_r(4'd8, s);
            if (s == 32'd0) return;
        end
        chk(1'b0, "R3 run did not go idle", s, 0);
    endtask

    task automatic finish_sim();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Bus responder and monitor, working at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            bus_cmd_ready = lfsr[0] | lfsr[3];
            bus_wready    = lfsr[1] | lfsr[5];
            if (rd_next > 0) begin
                rd_left = rd_next; rd_a = rd_next_a; rd_next = 0;
            end
            if (rd_left > 0 && (lfsr[2] | lfsr[6])) begin
                bus_rvalid = 1'b1;
                bus_rdata  = pat(rd_a) ^ (inj ? DW'(1) : DW'(0));
                rd_a       = rd_a + 32'(B);
                rd_left--;
            end else begin
                bus_rvalid = 1'b0;
            end
            if (bus_wvalid && bus_wready) begin
                chk(bus_wdata == pat(wr_a), "R8 write pattern", bus_wdata, pat(wr_a));
                wr_a = wr_a + 32'(B);
            end
            if (bus_cmd_valid && bus_cmd_ready) begin
                logic [31:0] ea;
                int          el, reg_len;
                reg_len = bus_cmd_write ? m_wlen : m_rlen;
                el = (reg_len == 0) ? 1 : reg_len;
                ea = bus_cmd_write ? m_wbase + m_woff : m_rbase + m_roff;
                chk(bus_cmd_addr == ea, "R7 burst address", bus_cmd_addr, ea);
                chk(int'(bus_cmd_beats) == el, "R12 burst beats", bus_cmd_beats, el);
                if (expect_alt && have_last)
                    chk(bus_cmd_write != last_w, "R5 alternation", bus_cmd_write, !last_w);
                last_w = bus_cmd_write; have_last = 1'b1;
                if (bus_cmd_write) begin
                    wr_a = bus_cmd_addr;
                    m_woff = m_woff + 32'(el * B);
                    if (m_woff >= m_region) m_woff = '0;
                end else begin
                    rd_next = el; rd_next_a = bus_cmd_addr;
                    m_roff = m_roff + 32'(el * B);
                    if (m_roff >= m_region) m_roff = '0;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_sim();
    end

    initial begin
        logic [31:0] d, d2, c1, c2;
        int          el, beats_total;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a <= 12; a++) begin
            reg_r(4'(a), d);
            chk(d == 32'd0, "R1 register after reset", d, 0);
        end
        chk(bus_cmd_valid == 1'b0 && bus_wvalid == 1'b0, "R1 bus idle after reset", bus_cmd_valid, 0);

        // R2: configuration readback
        reg_w(4'd1, 32'h1234_5678); reg_r(4'd1, d);
        chk(d == 32'h1234_5678, "R2 read base readback", d, 32'h1234_5678);
        reg_w(4'd3, 32'h1FF); reg_r(4'd3, d);
        chk(d == 32'hFF, "R2 length truncated to LEN_W", d, 32'hFF);
        reg_w(4'd7, 32'hABCD0); reg_r(4'd7, d);
        chk(d == 32'hABCD0, "R2 region readback", d, 32'hABCD0);
        reg_w(4'd5, 32'h77); reg_r(4'd5, d);
        chk(d == 32'h77, "R2 write count readback", d, 32'h77);

        // Vector table walk: R3 R7 R8 R9 R10 R12
        for (int i = 0; i < NV; i++) begin
            clear_all();
            m_rbase = 32'h1000_0000 + 32'(i * 32'h400);
            m_wbase = 32'h2000_0000 + 32'(i * 32'h400);
            m_rlen = int'(VECS[i].len); m_wlen = int'(VECS[i].len);
            m_region = 32'(VECS[i].region);
            inj = VECS[i].inj;
            reg_w(4'd1, m_rbase); reg_w(4'd2, 32'(VECS[i].rcnt)); reg_w(4'd3, 32'(VECS[i].len));
            reg_w(4'd4, m_wbase); reg_w(4'd5, 32'(VECS[i].wcnt)); reg_w(4'd6, 32'(VECS[i].len));
            reg_w(4'd7, m_region);
            reg_w(4'd0, {30'd0, VECS[i].wr, VECS[i].rd});
            wait_idle();
            el = (VECS[i].len == 0) ? 1 : int'(VECS[i].len);
            beats_total = (VECS[i].rd ? int'(VECS[i].rcnt) * el : 0)
                        + (VECS[i].wr ? int'(VECS[i].wcnt) * el : 0);
            reg_r(4'd9, d);
            chk(d == (VECS[i].rd ? 32'(VECS[i].rcnt) : 0), "R3 read bursts done", d, VECS[i].rcnt);
            reg_r(4'd10, d);
            chk(d == (VECS[i].wr ? 32'(VECS[i].wcnt) : 0), "R3 write bursts done", d, VECS[i].wcnt);
            reg_r(4'd12, d);
            d2 = (VECS[i].rd && VECS[i].inj) ? 32'(int'(VECS[i].rcnt) * el) : 32'd0;
            chk(d == d2, "R9 mismatch count", d, d2);
            reg_r(4'd11, c1);
            if (beats_total == 0) chk(c1 == 0, "R10 no cycles when no work", c1, 0);
            else chk(c1 >= 32'(beats_total), "R10 cycles cover beats", c1, beats_total);
            repeat (10) @(negedge clk);
            reg_r(4'd11, c2);
            chk(c2 == c1, "R10 cycles hold while idle", c2, c1);
            reg_w(4'd0, 32'h0);
            inj = 1'b0;
        end

        // R4 and R5: both channels looping, strict alternation
        clear_all();
        m_rbase = 32'h3000_0000; m_wbase = 32'h4000_0000;
        m_rlen = 2; m_wlen = 2; m_region = 32'h100;
        reg_w(4'd1, m_rbase); reg_w(4'd2, 32'd1); reg_w(4'd3, 32'd2);
        reg_w(4'd4, m_wbase); reg_w(4'd5, 32'd1); reg_w(4'd6, 32'd2);
        reg_w(4'd7, m_region);
        have_last = 1'b0; expect_alt = 1'b1;
        reg_w(4'd0, 32'hF);
        repeat (400) @(negedge clk);
        reg_w(4'd0, 32'h0);
        wait_idle();
        expect_alt = 1'b0;
        reg_r(4'd9, d); reg_r(4'd10, d2);
        chk(d > 32'd1, "R4 loop runs past count", d, 2);
        chk((d == d2) || (d == d2 + 1) || (d2 == d + 1), "R5 balanced bursts", d, d2);
        repeat (50) @(negedge clk);
        reg_r(4'd9, c1);
        chk(c1 == d, "R4 no burst after enable cleared", c1, d);
        chk(bus_cmd_valid == 1'b0, "R4 bus idle after stop", bus_cmd_valid, 0);

        // R11: clear resets counters and offsets
        clear_all();
        for (int a = 9; a <= 12; a++) begin
            reg_r(4'(a), d);
            chk(d == 32'd0, "R11 counter cleared", d, 0);
        end
        reg_w(4'd2, 32'd1);
        reg_w(4'd0, 32'h1);
        wait_idle();
        reg_r(4'd9, d);
        chk(d == 32'd1, "R11 run after clear restarts at base", d, 1);
        reg_w(4'd0, 32'h0);

        finish_sim();
    end
endmodule